// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a combinational 32-bit datapath for saturating DSP arithmetic. It also holds a sticky saturation flag. An opcode picks one of several operations on two operands:

- signed add, subtract or doubling that clamps to the signed limits;
- unsigned add or subtract that clamps to all ones or to zero;
- a plain add that wraps but still reports signed overflow;
- saturation of a signed value to a programmable bit width, with a signed or an unsigned result.

The width saturation comes in two forms. One works on the whole word. The other works on two independent halfword lanes.

The result follows the inputs within the same cycle. The flag is a register. On a rising clock edge with `en` high, it is set if the current operation clamped (or, for the wrapping add, overflowed). It stays set until `clr` is asserted or the block is reset. Software-style code can run a sequence of operations and then test once whether any of them lost precision.

Top module: `sat_alu`

## Requirements
- R1: Signed saturating add (opcode 1): when both operands have the same sign and the sum's sign differs, the result is 0x7FFFFFFF for non-negative operands and 0x80000000 for negative ones, and this counts as a clamp; otherwise the result is the sum.
- R2: Signed saturating subtract (opcode 2): when the operand signs differ and the difference's sign differs from the first operand, the result clamps as in R1 according to the first operand's sign; otherwise it is `opa - opb`.
- R3: Doubling (opcode 3): an `opa` of 0x40000000 or more (signed) gives 0x7FFFFFFF, an `opa` of 0xC0000000 or less gives 0x80000000, both counting as clamps; any other input gives `opa` shifted left by one.
- R4: Unsigned add (opcode 4) gives all ones on carry-out, and unsigned subtract (opcode 5) gives zero when `opb > opa`, both counting as clamps; otherwise each gives the modular result.
- R5: Wrapping add (opcode 0) always returns the modular sum and counts signed overflow (the R1 condition) as a clamp event.
- R6: Signed width saturation (opcode 6): with n = `sat_bits`, if `opa` shifted right arithmetically by n is above 0 the result is 2^n-1, if it is below -1 the result is the bitwise inverse of 2^n-1 (both clamps), and otherwise it is `opa`.
- R7: Unsigned width saturation (opcode 7): a negative `opa` gives 0, an `opa` above 2^n-1 gives 2^n-1 (both clamps), and otherwise the result is `opa`.
- R8: Halfword forms (opcode 8 signed, opcode 9 unsigned) sign-extend bits 15:0 and bits 31:16 separately, apply R6 or R7 to each lane, and place each lane's low 16 result bits in the matching half of the result; a clamp in either lane counts.
- R9: The flag is set at a rising clock edge only when `en` is high and the current operation counts a clamp; with `en` low, or with no clamp, the flag does not rise.
- R10: Once set, the flag stays set until `clr` is high at a rising edge, which clears it even if a clamp occurs in the same cycle; reset clears it.
- R11: Opcodes 10 to 15 pass `opa` to the result unchanged and never count a clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Lets the current operation update the flag |
| clr | input | 1 | Clears the sticky flag (takes priority) |
| op | input | 4 | Operation select |
| opa | input | 32 | First operand / value to saturate |
| opb | input | 32 | Second operand |
| sat_bits | input | 5 | Saturation width n for opcodes 6 to 9 |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
On every cycle the assertions check four properties:
- signed adds of like-signed operands never flip sign;
- unsigned add never falls below `opa`, and unsigned subtract never rises above it;
- a signed width saturation always fits in n+1 signed bits;
- the flag holds, clears and stays low as R9 and R10 require.

The exact clamp values, the doubling boundaries, the wrapping add and lane independence in the halfword forms only show up in the bench's directed scenarios. The same holds for the pass-through opcodes and the clear-beats-set case.

// File: rtl/sat_pkg.sv
package sat_pkg;
   typedef enum logic [3:0] {
      OP_WADD   = 4'd0,
      OP_SADD   = 4'd1,
      OP_SSUB   = 4'd2,
      OP_SDBL   = 4'd3,
      OP_UADD   = 4'd4,
      OP_USUB   = 4'd5,
      OP_SSAT   = 4'd6,
      OP_USAT   = 4'd7,
      OP_SSAT16 = 4'd8,
      OP_USAT16 = 4'd9
   } sat_op_e;
endpackage

// File: rtl/sat_arith.sv
module sat_arith #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] wadd_res,
   output logic          wadd_ovf,
   output logic [DW-1:0] sadd_res,
   output logic [DW-1:0] ssub_res,
   output logic          ssub_ovf,
   output logic [DW-1:0] sdbl_res,
   output logic          sdbl_ovf,
   output logic [DW-1:0] uadd_res,
   output logic          uadd_ovf,
   output logic [DW-1:0] usub_res,
   output logic          usub_ovf
);
   localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   logic [DW:0]   sum_x;
   logic [DW-1:0] diff;
   logic [DW-1:0] clamp_a;

   assign sum_x   = {1'b0, a} + {1'b0, b};
   assign diff    = a - b;
   assign clamp_a = a[DW-1] ? SMIN : SMAX;

   always_comb begin
      wadd_res = sum_x[DW-1:0];
      wadd_ovf = (a[DW-1] == b[DW-1]) && (sum_x[DW-1] != a[DW-1]);
      sadd_res = wadd_ovf ? clamp_a : sum_x[DW-1:0];

      ssub_ovf = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
      ssub_res = ssub_ovf ? clamp_a : diff;

      // top two bits disagree: doubling leaves the signed range,
      // except the exact lower limit, which is also reported
      sdbl_ovf = (a[DW-1] != a[DW-2]) || (a == {2'b11, {(DW-2){1'b0}}});
      sdbl_res = sdbl_ovf ? clamp_a : {a[DW-2:0], 1'b0};

      uadd_ovf = sum_x[DW];
      uadd_res = uadd_ovf ? '1 : sum_x[DW-1:0];

      usub_ovf = (b > a);
      usub_res = usub_ovf ? '0 : diff;
   end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
   parameter int W = 32,
   localparam int NW = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [NW-1:0] nbits,
   input  logic          uns,
   output logic [W-1:0]  res,
   output logic          hit
);
   logic signed [W-1:0] top;
   logic        [W-1:0] mask;

   assign top  = $signed(val) >>> nbits;
   assign mask = ({{(W-1){1'b0}}, 1'b1} << nbits) - {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      res = val;
      hit = 1'b0;
      if (uns) begin
         if (val[W-1]) begin
            res = '0;
            hit = 1'b1;
         end else if (val > mask) begin
            res = mask;
            hit = 1'b1;
         end
      end else begin
         if (!top[W-1] && (top != '0)) begin
            res = mask;
            hit = 1'b1;
         end else if (top[W-1] && (top != '1)) begin
            res = ~mask;
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_pkg::*;
#(
   parameter int DW = 32,
   localparam int HW = DW / 2,
   localparam int NW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic [3:0]    op,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   input  logic [NW-1:0] sat_bits,
   output logic [DW-1:0] result,
   output logic          sat_flag
);
   initial begin
      assert (DW >= 8 && DW % 2 == 0)
         else $error("sat_alu: DW must be even and at least 8");
   end

   logic [DW-1:0] wadd_r, sadd_r, ssub_r, sdbl_r, uadd_r, usub_r;
   logic          wadd_v, ssub_v, sdbl_v, uadd_v, usub_v;

   sat_arith #(.DW(DW)) u_arith (
      .a(opa), .b(opb),
      .wadd_res(wadd_r), .wadd_ovf(wadd_v),
      .sadd_res(sadd_r),
      .ssub_res(ssub_r), .ssub_ovf(ssub_v),
      .sdbl_res(sdbl_r), .sdbl_ovf(sdbl_v),
      .uadd_res(uadd_r), .uadd_ovf(uadd_v),
      .usub_res(usub_r), .usub_ovf(usub_v)
   );

   logic          lane_uns;
   logic [DW-1:0] word_r;
   logic          word_v;

   assign lane_uns = (op == OP_USAT) || (op == OP_USAT16);

   sat_clamp #(.W(DW)) u_word (
      .val(opa), .nbits(sat_bits), .uns(lane_uns), .res(word_r), .hit(word_v)
   );

   logic [1:0][DW-1:0] lane_r;
   logic [1:0]         lane_v;
   logic [DW-1:0]      pack_r;

   for (genvar k = 0; k < 2; k++) begin : g_lane
      logic [DW-1:0] ext;
      assign ext = {{HW{opa[k*HW+HW-1]}}, opa[k*HW +: HW]};
      sat_clamp #(.W(DW)) u_half (
         .val(ext), .nbits(sat_bits), .uns(lane_uns),
         .res(lane_r[k]), .hit(lane_v[k])
      );
      assign pack_r[k*HW +: HW] = lane_r[k][HW-1:0];
   end

   logic hit_now;

   always_comb begin
      result  = opa;
      hit_now = 1'b0;
      unique case (op)
         OP_WADD:   begin result = wadd_r; hit_now = wadd_v;   end
         OP_SADD:   begin result = sadd_r; hit_now = wadd_v;   end
         OP_SSUB:   begin result = ssub_r; hit_now = ssub_v;   end
         OP_SDBL:   begin result = sdbl_r; hit_now = sdbl_v;   end
         OP_UADD:   begin result = uadd_r; hit_now = uadd_v;   end
         OP_USUB:   begin result = usub_r; hit_now = usub_v;   end
         OP_SSAT,
         OP_USAT:   begin result = word_r; hit_now = word_v;   end
         OP_SSAT16,
         OP_USAT16: begin result = pack_r; hit_now = |lane_v;  end
         default:   begin result = opa;    hit_now = 1'b0;     end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sat_flag <= 1'b0;
      else if (clr)        sat_flag <= 1'b0;
      else if (en && hit_now) sat_flag <= 1'b1;
   end

   logic signed [DW-1:0] ssat_span;
   assign ssat_span = $signed(result) >>> sat_bits;

   // R1
   sadd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SADD && opa[DW-1] == opb[DW-1]) |-> result[DW-1] == opa[DW-1]);
   // R4
   uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_UADD) |-> result >= opa);
   // R4
   usub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_USUB) |-> result <= opa);
   // R6
   ssat_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SSAT) |-> (ssat_span == '0 || ssat_span == '1));
   // R9
   no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && !en) |=> !sat_flag);
   // R10
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !clr) |=> sat_flag);
   // R10
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !sat_flag);
endmodule

// File: tb/sim_sat_alu.sv
module sim_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        clr = 1'b0;
   logic [3:0]  op = 4'd0;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  sat_bits = '0;
   logic [31:0] result;
   logic        sat_flag;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sat_alu u0 (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .op(op),
               .opa(opa), .opb(opb), .sat_bits(sat_bits),
               .result(result), .sat_flag(sat_flag));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      @(negedge clk); clr = 1'b1; en = 1'b0;
      @(negedge clk); clr = 1'b0;
   endtask

   // one operation from a cleared flag: result in-cycle, flag after the edge
   task automatic run_op(input string req, input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] n,
                         input logic [31:0] exp_r, input logic exp_f);
      clear_flag();
      op = o; opa = a; opb = b; sat_bits = n; en = 1'b1;
      #1 check(req, result, exp_r);
      @(negedge clk); en = 1'b0;
      check(req, {31'b0, sat_flag}, {31'b0, exp_f});
   endtask

   task automatic t_reset();
      check("R10 reset", {31'b0, sat_flag}, 32'd0);
   endtask

   task automatic t_sadd();
      run_op("R1", 4'd1, 32'h7FFFFFFF, 32'h1, 0, 32'h7FFFFFFF, 1);
      run_op("R1", 4'd1, 32'h80000000, 32'hFFFFFFFF, 0, 32'h80000000, 1);
      run_op("R1", 4'd1, 32'd5, 32'd7, 0, 32'd12, 0);
   endtask

   task automatic t_ssub();
      run_op("R2", 4'd2, 32'h80000000, 32'h1, 0, 32'h80000000, 1);
      run_op("R2", 4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 32'h7FFFFFFF, 1);
      run_op("R2", 4'd2, 32'd10, 32'd3, 0, 32'd7, 0);
   endtask

   task automatic t_dbl();
      run_op("R3", 4'd3, 32'h40000000, 0, 0, 32'h7FFFFFFF, 1);
      run_op("R3", 4'd3, 32'h3FFFFFFF, 0, 0, 32'h7FFFFFFE, 0);
      run_op("R3", 4'd3, 32'hC0000000, 0, 0, 32'h80000000, 1);
      run_op("R3", 4'd3, 32'hC0000001, 0, 0, 32'h80000002, 0);
   endtask

   task automatic t_unsigned();
      run_op("R4", 4'd4, 32'hFFFFFFF0, 32'h20, 0, 32'hFFFFFFFF, 1);
      run_op("R4", 4'd4, 32'd1, 32'd2, 0, 32'd3, 0);
      run_op("R4", 4'd5, 32'd3, 32'd5, 0, 32'd0, 1);
      run_op("R4", 4'd5, 32'd5, 32'd3, 0, 32'd2, 0);
   endtask

   task automatic t_wrap();
      run_op("R5", 4'd0, 32'h7FFFFFFF, 32'h1, 0, 32'h80000000, 1);
      run_op("R5", 4'd0, 32'hFFFFFFFF, 32'h1, 0, 32'h00000000, 0);
   endtask

   task automatic t_ssat();
      run_op("R6", 4'd6, 32'd300, 0, 5'd8, 32'd255, 1);
      run_op("R6", 4'd6, -32'sd300, 0, 5'd8, 32'hFFFFFF00, 1);
      run_op("R6", 4'd6, 32'd100, 0, 5'd8, 32'd100, 0);
      run_op("R6", 4'd6, -32'sd200, 0, 5'd8, 32'hFFFFFF38, 0);
   endtask

   task automatic t_usat();
      run_op("R7", 4'd7, -32'sd5, 0, 5'd8, 32'd0, 1);
      run_op("R7", 4'd7, 32'd300, 0, 5'd8, 32'd255, 1);
      run_op("R7", 4'd7, 32'd200, 0, 5'd8, 32'd200, 0);
   endtask

   task automatic t_half();
      run_op("R8", 4'd8, 32'h0100FFF0, 0, 5'd4, 32'h000FFFF0, 1);
      run_op("R8", 4'd8, 32'h00050003, 0, 5'd4, 32'h00050003, 0);
      run_op("R8", 4'd8, 32'h00028000, 0, 5'd4, 32'h0002FFF0, 1);
      run_op("R8", 4'd9, 32'hFFFF0020, 0, 5'd4, 32'h0000000F, 1);
   endtask

   task automatic t_passthru();
      run_op("R11", 4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 32'h7FFFFFFF, 0);
      run_op("R11", 4'd15, 32'hFFFFFFFF, 32'h1, 5'd2, 32'hFFFFFFFF, 0);
   endtask

   task automatic t_enable();
      clear_flag();
      op = 4'd1; opa = 32'h7FFFFFFF; opb = 32'h1; en = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R9 enable low", {31'b0, sat_flag}, 32'd0);
   endtask

   task automatic t_sticky();
      clear_flag();
      op = 4'd1; opa = 32'h7FFFFFFF; opb = 32'h1; en = 1'b1;
      @(negedge clk);
      opa = 32'd1; opb = 32'd1;
      @(negedge clk); @(negedge clk);
      check("R10 sticky", {31'b0, sat_flag}, 32'd1);
      opa = 32'h7FFFFFFF; clr = 1'b1;
      @(negedge clk); clr = 1'b0; en = 1'b0;
      check("R10 clear wins", {31'b0, sat_flag}, 32'd0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_sadd();
      t_ssub();
      t_dbl();
      t_unsigned();
      t_wrap();
      t_ssat();
      t_usat();
      t_half();
      t_passthru();
      t_enable();
      t_sticky();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule